// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a 16-bit physical address through a small table of segments. The two most significant address bits pick one of four segment entries and the remaining twelve bits are an offset within that segment. Every entry holds a 16-bit base, a 16-bit limit, an in-use flag and a write-enable flag. A translation that passes every check returns base plus offset. Otherwise the block returns a fault code and a zero address.

Software running in kernel mode loads the table one entry at a time through a write port. On a context switch it rewrites all four entries. A write attempted while the kernel-mode input is low changes nothing and raises a one-cycle illegal-access flag. The translate side accepts a request in every cycle and answers exactly one cycle later, so requests can be issued back to back.

Top module: `seg_xlat`

## Requirements
- R1: The segment index is virtual address bits [13:12] and the offset is bits [11:0].
- R2: A request that passes every check returns physical address = entry base + zero-extended offset, with fault code 0 (none).
- R3: An offset greater than or equal to the entry limit gives fault code 2 (limit) and physical address 0.
- R4: A request to an entry whose in-use flag is clear gives fault code 1 (unused) and physical address 0. This code takes precedence over the limit and write checks.
- R5: A write request to an entry whose write-enable flag is clear gives fault code 3 (write protect) and physical address 0. Read requests to that entry are translated normally. A limit fault takes precedence over a write-protect fault.
- R6: A table write takes effect only when kernel_mode is high. A write with kernel_mode low leaves the entry unchanged and raises cfg_illegal for exactly the next cycle.
- R7: rsp_valid is high in the cycle after each accepted request and low in every other cycle. Requests in consecutive cycles each get their own response.
- R8: After reset every entry is unused, and rsp_valid and cfg_illegal are low.
- R9: Rewriting the entries replaces the earlier mappings for every request accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kernel_mode | input | 1 | High when privileged software is running |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | Base value to write |
| cfg_limit | input | 16 | Limit value to write |
| cfg_used | input | 1 | In-use flag to write |
| cfg_wr_en | input | 1 | Write-enable flag to write |
| cfg_illegal | output | 1 | One-cycle pulse after a rejected table write |
| req_valid | input | 1 | Translation request |
| req_va | input | 14 | Virtual address |
| req_write | input | 1 | High for a store access |
| rsp_valid | output | 1 | Response available |
| rsp_pa | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 unused, 2 limit, 3 write protect |

## Verification
A corrupted entry shows up as a wrong address or a wrong fault code on the first response that selects that entry, one cycle after the request. The bench therefore probes every entry at its lowest offset, its highest offset and its first out-of-range offset, and it probes with both access types. A rejected write that leaks into the table would only show on a later lookup, so each rejected write is followed at once by a translation through the entry it targeted. The context-switch scenario repeats the same addresses after a reload, so any stale base would appear in the very next response.

// File: rtl/seg_xlat_pkg.sv
// Shared types for the segment translator.
// Assumes: fault encoding is visible at the top ports as a 2-bit code.
package seg_xlat_pkg;
    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_UNUSED = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_WPROT  = 2'd3
    } fault_e;

    typedef struct packed {
        logic        used;
        logic        wr_en;
        logic [15:0] base;
        logic [15:0] limit;
    } seg_ent_t;
endpackage

// File: rtl/seg_table.sv
// Segment entry storage with a privilege-gated write port.
// Assumes: one write per cycle; read is combinational from registered state,
// so a write is seen by lookups after the edge that stores it.
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int SEG_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kernel_mode,
    input  logic                wr_req,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  seg_ent_t            wr_data,
    input  logic [SEG_BITS-1:0] rd_idx,
    output seg_ent_t            rd_data,
    output logic                illegal
);
    localparam int NSEG = 1 << SEG_BITS;

    seg_ent_t ent [NSEG];
    logic     wr_ok;

    assign wr_ok = wr_req && kernel_mode;

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        // Hold one entry; cleared to unused on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (wr_ok && (wr_idx == SEG_BITS'(i))) begin
                ent[i] <= wr_data;
            end
        end
    end

    // Select the entry addressed by the lookup.
    always_comb begin
        rd_data = ent[rd_idx];
    end

    // Flag a write attempted outside kernel mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal <= 1'b0;
        end else begin
            illegal <= wr_req && !kernel_mode;
        end
    end
endmodule

// File: rtl/seg_check.sv
// Combinational permission and range check plus address formation.
// Assumes: BASE_W > OFF_BITS; the sum wraps modulo 2**BASE_W.
// Priority: unused, then limit, then write protect.
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int OFF_BITS = 12,
    parameter int BASE_W   = 16
) (
    input  seg_ent_t            ent,
    input  logic [OFF_BITS-1:0] offset,
    input  logic                is_write,
    output fault_e              fault,
    output logic [BASE_W-1:0]   pa
);
    localparam int PAD = BASE_W - OFF_BITS;

    logic [BASE_W-1:0] off_ext;

    assign off_ext = {{PAD{1'b0}}, offset};

    // Decide the fault code and the address.
    always_comb begin
        if (!ent.used) begin
            fault = FLT_UNUSED;
        end else if (off_ext >= ent.limit) begin
            fault = FLT_LIMIT;
        end else if (is_write && !ent.wr_en) begin
            fault = FLT_WPROT;
        end else begin
            fault = FLT_NONE;
        end
        pa = (fault == FLT_NONE) ? (ent.base + off_ext) : '0;
    end
endmodule

// File: rtl/seg_xlat.sv
// Top: segment translator with a gated table-load port and a
// one-cycle request/response translate port.
// Assumes: always ready; one response per request, one cycle later.
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_BITS = 2,
    parameter int OFF_BITS = 12,
    parameter int BASE_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         kernel_mode,
    input  logic                         cfg_we,
    input  logic [SEG_BITS-1:0]          cfg_idx,
    input  logic [BASE_W-1:0]            cfg_base,
    input  logic [BASE_W-1:0]            cfg_limit,
    input  logic                         cfg_used,
    input  logic                         cfg_wr_en,
    output logic                         cfg_illegal,
    input  logic                         req_valid,
    input  logic [SEG_BITS+OFF_BITS-1:0] req_va,
    input  logic                         req_write,
    output logic                         rsp_valid,
    output logic [BASE_W-1:0]            rsp_pa,
    output logic [1:0]                   rsp_fault
);
    localparam int VA_W = SEG_BITS + OFF_BITS;

    seg_ent_t            wr_ent;
    seg_ent_t            rd_ent;
    logic [SEG_BITS-1:0] va_seg;
    logic [OFF_BITS-1:0] va_off;
    fault_e              chk_fault;
    logic [BASE_W-1:0]   chk_pa;

    assign va_seg = req_va[VA_W-1:OFF_BITS];
    assign va_off = req_va[OFF_BITS-1:0];

    // Pack the write fields into an entry.
    always_comb begin
        wr_ent       = '0;
        wr_ent.used  = cfg_used;
        wr_ent.wr_en = cfg_wr_en;
        wr_ent.base  = cfg_base;
        wr_ent.limit = cfg_limit;
    end

    seg_table #(.SEG_BITS(SEG_BITS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .kernel_mode(kernel_mode),
        .wr_req     (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_data    (wr_ent),
        .rd_idx     (va_seg),
        .rd_data    (rd_ent),
        .illegal    (cfg_illegal)
    );

    seg_check #(.OFF_BITS(OFF_BITS), .BASE_W(BASE_W)) u_check (
        .ent     (rd_ent),
        .offset  (va_off),
        .is_write(req_write),
        .fault   (chk_fault),
        .pa      (chk_pa)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= chk_pa;
                rsp_fault <= chk_fault;
            end
        end
    end
endmodule

// File: rtl/seg_xlat_chk.sv
// Protocol checker for seg_xlat, attached with bind.
// Assumes: the same parameter values as the bound instance.
module seg_xlat_chk #(
    parameter int SEG_BITS = 2,
    parameter int OFF_BITS = 12,
    parameter int BASE_W   = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         kernel_mode,
    input logic                         cfg_we,
    input logic                         cfg_illegal,
    input logic                         req_valid,
    input logic [SEG_BITS+OFF_BITS-1:0] req_va,
    input logic                         rsp_valid,
    input logic [BASE_W-1:0]            rsp_pa,
    input logic [1:0]                   rsp_fault
);
    // R7: a request is answered in the next cycle
    p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no response without a request
    p_no_spurious_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a faulting response carries a zero address
    p_fault_zero_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0));

    // R6: a rejected write is flagged in the next cycle
    p_illegal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kernel_mode) |=> cfg_illegal);

    // R6: a kernel write or no write leaves the flag low
    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !kernel_mode) |=> !cfg_illegal);

    // R4: the segment of a request is a known value
    p_seg_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$isunknown(req_va[SEG_BITS+OFF_BITS-1:OFF_BITS]));
endmodule

bind seg_xlat seg_xlat_chk #(
    .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .BASE_W(BASE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .cfg_we(cfg_we),
    .cfg_illegal(cfg_illegal), .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_xlat.sv
// Directed bench for seg_xlat: one task per scenario.
module tb_seg_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_limit = '0;
    logic        cfg_used = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_illegal;
    logic        req_valid = 1'b0;
    logic [13:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_pa;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_xlat dut (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_used(cfg_used), .cfg_wr_en(cfg_wr_en),
        .cfg_illegal(cfg_illegal), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one entry; sample the illegal flag after the edge.
    task automatic load(input logic km, input logic [1:0] idx, input logic [15:0] b,
                        input logic [15:0] l, input logic u, input logic w);
        @(negedge clk);
        kernel_mode = km; cfg_we = 1'b1; cfg_idx = idx;
        cfg_base = b; cfg_limit = l; cfg_used = u; cfg_wr_en = w;
        @(posedge clk); #1;
        check(km ? "R6 no flag on kernel write" : "R6 flag on user write",
              {31'd0, cfg_illegal}, {31'd0, !km});
        @(negedge clk);
        cfg_we = 1'b0; kernel_mode = 1'b0;
        @(posedge clk); #1;
        check("R6 flag lasts one cycle", {31'd0, cfg_illegal}, 32'd0);
    endtask

    // Issue one request and check the response one cycle later.
    task automatic xlate(input string tag, input logic [1:0] seg, input logic [11:0] off,
                         input logic wr, input logic [15:0] exp_pa, input logic [1:0] exp_f);
        @(negedge clk);
        req_valid = 1'b1; req_va = {seg, off}; req_write = wr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " pa"}, {16'd0, rsp_pa}, {16'd0, exp_pa});
        check({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R8 rsp_valid low", {31'd0, rsp_valid}, 32'd0);
        check("R8 illegal low", {31'd0, cfg_illegal}, 32'd0);
        xlate("R8 empty table seg3", 2'd3, 12'h000, 1'b0, 16'h0, 2'd1);
        xlate("R8 empty table seg0", 2'd0, 12'h010, 1'b1, 16'h0, 2'd1);
    endtask

    task automatic t_layout();
        load(1'b1, 2'd0, 16'h4000, 16'h0700, 1'b1, 1'b0);
        load(1'b1, 2'd1, 16'h0000, 16'h0500, 1'b1, 1'b1);
        load(1'b1, 2'd2, 16'h0000, 16'h0000, 1'b0, 1'b0);
        load(1'b1, 2'd3, 16'h2000, 16'h1000, 1'b1, 1'b1);
    endtask

    task automatic t_translate();
        xlate("R1 R2 seg3 top", 2'd3, 12'hfff, 1'b0, 16'h2fff, 2'd0);
        xlate("R2 seg0 base", 2'd0, 12'h000, 1'b0, 16'h4000, 2'd0);
        xlate("R2 seg0 last", 2'd0, 12'h6ff, 1'b0, 16'h46ff, 2'd0);
        xlate("R3 seg0 at limit", 2'd0, 12'h700, 1'b0, 16'h0, 2'd2);
        xlate("R2 seg1 last", 2'd1, 12'h4ff, 1'b1, 16'h04ff, 2'd0);
        xlate("R3 seg1 at limit", 2'd1, 12'h500, 1'b0, 16'h0, 2'd2);
        xlate("R4 seg2 unused", 2'd2, 12'h000, 1'b0, 16'h0, 2'd1);
        xlate("R5 write read-only", 2'd0, 12'h010, 1'b1, 16'h0, 2'd3);
        xlate("R5 read read-only", 2'd0, 12'h010, 1'b0, 16'h4010, 2'd0);
        xlate("R5 limit over wprot", 2'd0, 12'h700, 1'b1, 16'h0, 2'd2);
    endtask

    task automatic t_illegal();
        load(1'b0, 2'd2, 16'h1234, 16'h0fff, 1'b1, 1'b1);
        xlate("R6 seg2 still unused", 2'd2, 12'h000, 1'b0, 16'h0, 2'd1);
        load(1'b0, 2'd3, 16'h5000, 16'h0010, 1'b1, 1'b0);
        xlate("R6 seg3 unchanged", 2'd3, 12'h800, 1'b1, 16'h2800, 2'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_va = {2'd3, 12'h001}; req_write = 1'b0;
        @(posedge clk); #1;
        check("R7 first valid", {31'd0, rsp_valid}, 32'd1);
        check("R7 first pa", {16'd0, rsp_pa}, 32'h2001);
        req_va = {2'd1, 12'h002};
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R7 second valid", {31'd0, rsp_valid}, 32'd1);
        check("R7 second pa", {16'd0, rsp_pa}, 32'h0002);
        @(posedge clk); #1;
        check("R7 idle valid low", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_switch();
        load(1'b1, 2'd1, 16'h4700, 16'h0500, 1'b1, 1'b1);
        load(1'b1, 2'd3, 16'h3000, 16'h1000, 1'b1, 1'b1);
        xlate("R9 seg1 moved", 2'd1, 12'h4ff, 1'b0, 16'h4bff, 2'd0);
        xlate("R9 seg3 moved", 2'd3, 12'hfff, 1'b1, 16'h3fff, 2'd0);
        xlate("R9 seg0 kept", 2'd0, 12'h123, 1'b0, 16'h4123, 2'd0);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_translate();
        t_illegal();
        t_back_to_back();
        t_switch();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule